// File: doc/BRIEF.md
# Start-Triggered Oversampling UART Receiver

This block receives asynchronous serial bytes without locking a phase to the sender. A divider produces a sample strobe at three times the baud rate. An active-low trigger input, wired at board or chip level to the same serial line, is checked on every sample strobe while the receiver is idle. The falling edge of the start bit therefore launches a frame. The rest of the start bit is absorbed. The receiver then records a programmed number of raw samples into a word and does not look at the trigger again until that word is complete.

Once the word is complete, each bit is recovered by taking the centre sample of its group of three. The eight data bits form a byte, and the centre sample of the stop group is checked. The byte is held on a parallel output together with a full flag, a per-byte framing-error flag and a sticky overrun flag. With 8 data bits and 1 stop bit, the capture length field is programmed to 26, which gives 27 samples. The sample rate is the clock frequency divided by (divider + 1). For example, 9600 baud needs 28,800 samples per second.

Top module: `ovs_uart_rx`

## Requirements
- R1: A sample strobe occurs once every `div_i`+1 clock cycles. With `div_i`=0 the strobe is present on every cycle. The bench uses a bit time of 3×(`div_i`+1) cycles.
- R2: While idle, a low level on `sync_ni` at a sample strobe starts a frame. The next two strobes are skipped (the remainder of the start bit), and capture begins on the strobe after those.
- R3: The receiver captures `len_m1_i`+1 samples, one per strobe. `full_o` rises on the clock edge after the edge following the last capture strobe. `sync_ni` has no effect during the skip and capture phases, so a data byte of 0x00 yields exactly one frame.
- R4: Capture sample i is stored at index i of the raw word (LSB first). Data bit k of `byte_o` is taken from raw index 3k+1.
- R5: The stop bit is taken from raw index 25. If it is 0, `ferr_o` is 1 while that byte is held; otherwise `ferr_o` is 0.
- R6: When a frame completes, `byte_o` is loaded and `full_o` is set. A one-cycle `rd_i` pulse clears `full_o` and leaves `byte_o` unchanged.
- R7: If a frame completes while `full_o` is 1 and `rd_i` is low, the new byte replaces the old one and `ovr_o` is set. `ovr_o` stays set until reset.
- R8: After the last capture strobe, the receiver watches `sync_ni` again from the next strobe. A frame whose start bit directly follows the previous stop bit is received.
- R9: During and after reset, `byte_o`=0x00, `full_o`=0, `ferr_o`=0 and `ovr_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial data line, idle high |
| sync_ni | input | 1 | Active-low frame trigger, tied to the serial line |
| div_i | input | DIV_W | Sample strobe divider, period `div_i`+1 cycles |
| len_m1_i | input | LEN_W | Number of samples to capture, minus one |
| rd_i | input | 1 | Read pulse that clears `full_o` |
| byte_o | output | DATA_BITS | Last decoded byte |
| full_o | output | 1 | A decoded byte is waiting |
| ferr_o | output | 1 | Stop sample of the held byte was 0 |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The hardest situation to reach is a frame start that falls directly on the end of a previous frame. In that case the receiver must be idle again on exactly the strobe where the new start bit is first seen. The bench drives two frames back to back with no idle gap, then checks both the second byte and the overrun flag. The second hard case is the timing of capture relative to an unknown strobe phase. The bench counts clock edges from the start-bit edge until the full flag rises, and checks that count against a window four cycles wide for two different capture lengths. The count must also be exact when the divider is zero.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;
  localparam int unsigned OVS      = 3;        // samples per bit
  localparam int unsigned SKIP_N   = OVS - 1;  // start samples after the trigger
  typedef enum logic [1:0] {ST_IDLE, ST_SKIP, ST_CAP} cap_st_e;
endpackage

// File: rtl/ovs_tick_gen.sv
module ovs_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R1: a nonzero divider never gives two strobes in a row
  a_r1_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/ovs_capture.sv
module ovs_capture
  import ovs_rx_pkg::*;
#(
  parameter int unsigned LEN_W   = 5,
  localparam int unsigned MAX_SMP = 1 << LEN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               rxd_i,
  input  logic               sync_ni,
  input  logic [LEN_W-1:0]   len_m1_i,
  output logic [MAX_SMP-1:0] word_o,
  output logic               done_o
);
  cap_st_e          st_q;
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      word_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          ST_IDLE: if (!sync_ni) begin
            st_q   <= ST_SKIP;
            cnt_q  <= '0;
            word_o <= '0;
          end
          ST_SKIP: begin
            if (cnt_q == LEN_W'(SKIP_N - 1)) begin
              st_q  <= ST_CAP;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_CAP: begin
            word_o[cnt_q] <= rxd_i;
            if (cnt_q == len_m1_i) begin
              st_q   <= ST_IDLE;
              done_o <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: capture index stays within the programmed length
  a_r3_cnt_in_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CAP) |-> (cnt_q <= len_m1_i));
  // R2: skip phase never falls straight back to idle
  a_r2_skip_to_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SKIP) |=> (st_q != ST_IDLE));
  // R8: completion leaves the receiver idle
  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (st_q == ST_IDLE));
endmodule

// File: rtl/ovs_decode.sv
module ovs_decode
  import ovs_rx_pkg::*;
#(
  parameter int unsigned MAX_SMP   = 32,
  parameter int unsigned DATA_BITS = 8,
  localparam int unsigned STOP_IDX = OVS * DATA_BITS + OVS / 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 done_i,
  input  logic [MAX_SMP-1:0]   word_i,
  input  logic                 rd_i,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 full_o,
  output logic                 ferr_o,
  output logic                 ovr_o
);
  logic [DATA_BITS-1:0] data_w;

  for (genvar k = 0; k < DATA_BITS; k++) begin : g_mid
    assign data_w[k] = word_i[OVS * k + OVS / 2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o <= '0;
      full_o <= 1'b0;
      ferr_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else if (done_i) begin
      byte_o <= data_w;
      ferr_o <= ~word_i[STOP_IDX];
      full_o <= 1'b1;
      if (full_o && !rd_i) ovr_o <= 1'b1;
    end else if (rd_i) begin
      full_o <= 1'b0;
    end
  end

  // R6: a finished frame always leaves a byte waiting
  a_r6_full_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> full_o);
  // R6: read alone empties the holding stage and keeps the byte
  a_r6_rd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> (!full_o && $stable(byte_o)));
  // R7: unread byte overwritten raises overrun
  a_r7_ovr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && full_o && !rd_i) |=> ovr_o);
  // R7: overrun is sticky
  a_r7_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> ovr_o);
endmodule

// File: rtl/ovs_uart_rx.sv
module ovs_uart_rx
  import ovs_rx_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned LEN_W     = 5,
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rxd_i,
  input  logic                 sync_ni,
  input  logic [DIV_W-1:0]     div_i,
  input  logic [LEN_W-1:0]     len_m1_i,
  input  logic                 rd_i,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 full_o,
  output logic                 ferr_o,
  output logic                 ovr_o
);
  localparam int unsigned MAX_SMP = 1 << LEN_W;

  logic               tick;
  logic               done;
  logic [MAX_SMP-1:0] word;

  ovs_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_i (div_i),
    .tick_o(tick)
  );

  ovs_capture #(.LEN_W(LEN_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .rxd_i   (rxd_i),
    .sync_ni (sync_ni),
    .len_m1_i(len_m1_i),
    .word_o  (word),
    .done_o  (done)
  );

  ovs_decode #(.MAX_SMP(MAX_SMP), .DATA_BITS(DATA_BITS)) u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_i(done),
    .word_i(word),
    .rd_i  (rd_i),
    .byte_o(byte_o),
    .full_o(full_o),
    .ferr_o(ferr_o),
    .ovr_o (ovr_o)
  );

  // R3: frame completion is a single-cycle event
  a_r3_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !done);
endmodule

// File: tb/sim_ovs_uart_rx.sv
module sim_ovs_uart_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic [15:0] div = 16'd3;
  logic [4:0]  len_m1 = 5'd26;
  logic        rd = 1'b0;
  logic [7:0]  byte_o;
  logic        full, ferr, ovr;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  ovs_uart_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .sync_ni(rxd),
    .div_i(div), .len_m1_i(len_m1), .rd_i(rd),
    .byte_o(byte_o), .full_o(full), .ferr_o(ferr), .ovr_o(ovr)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rd = 1'b0; rxd = 1'b1; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic int bit_time();
    return 3 * (int'(div) + 1);
  endfunction

  task automatic send(input logic [7:0] b, input logic stop);
    int bp = bit_time();
    @(negedge clk);
    rxd = 1'b0;
    repeat (bp) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      rxd = b[k];
      repeat (bp) @(negedge clk);
    end
    rxd = stop;
    repeat (bp) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic wait_full();
    for (int i = 0; i < 200 && !full; i++) @(negedge clk);
  endtask

  task automatic read_byte();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R9 byte", byte_o, 0);
    check("R9 full", full, 0);
    check("R9 ferr", ferr, 0);
    check("R9 ovr", ovr, 0);
  endtask

  task automatic t_bytes();
    logic [7:0] pat [3] = '{8'hA5, 8'h3C, 8'h81};
    foreach (pat[i]) begin
      send(pat[i], 1'b1);
      wait_full();
      check("R4 byte", byte_o, pat[i]);
      check("R5 ferr clear", ferr, 0);
      read_byte();
      check("R6 full cleared", full, 0);
      check("R6 byte kept", byte_o, pat[i]);
    end
  endtask

  // R3: all-zero data keeps the trigger low during capture; one frame only
  task automatic t_zero();
    send(8'h00, 1'b1);
    wait_full();
    check("R3 zero byte", byte_o, 0);
    read_byte();
    repeat (60) @(negedge clk);
    check("R3 no retrigger", full, 0);
  endtask

  task automatic t_ferr();
    send(8'h5A, 1'b0);
    wait_full();
    check("R5 ferr set", ferr, 1);
    check("R5 byte", byte_o, 8'h5A);
    read_byte();
    repeat (20) @(negedge clk);
    send(8'h5A, 1'b1);
    wait_full();
    check("R5 ferr cleared", ferr, 0);
    read_byte();
  endtask

  // R8/R7: back-to-back frames, the first left unread
  task automatic t_b2b_ovr();
    send(8'h12, 1'b1);
    send(8'hE7, 1'b1);
    wait_full();
    repeat (2) @(negedge clk);
    check("R8 b2b second byte", byte_o, 8'hE7);
    check("R7 ovr set", ovr, 1);
    read_byte();
    check("R7 ovr sticky", ovr, 1);
    do_reset();
    check("R7 ovr reset", ovr, 0);
  endtask

  task automatic lat(input logic [4:0] lm1, output int n);
    len_m1 = lm1;
    n = 0;
    fork
      send(8'hC3, 1'b1);
      begin
        @(negedge rxd);
        while (!full && n < 1000) begin
          @(posedge clk); n++; #1;
        end
      end
    join
    check("R3 lat byte", byte_o, 8'hC3);
    read_byte();
    repeat (20) @(negedge clk);
  endtask

  task automatic t_len();
    int n;
    lat(5'd26, n);
    check("R3 lat27 in window", int'(n >= 118 && n <= 121), 1);
    lat(5'd29, n);
    check("R3 lat30 in window", int'(n >= 130 && n <= 133), 1);
    len_m1 = 5'd26;
  endtask

  task automatic t_div0();
    int n;
    div = 16'd0;
    lat(5'd26, n);
    check("R1 div0 latency", n, 31);
    send(8'h96, 1'b1);
    wait_full();
    check("R1 div0 byte", byte_o, 8'h96);
    read_byte();
    div = 16'd3;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_idle();
    repeat (100) @(negedge clk);
    check("R2 idle no frame", full, 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_bytes();
    t_zero();
    t_ferr();
    t_b2b_ovr();
    t_len();
    t_div0();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule